// File: doc/BRIEF.md
# Vectored Exception Dispatch Sequencer

This block sits beside a pipeline's program-counter logic. It finds the handler for an exception by reading a table of handler addresses in data memory, so the handler address is not built into the hardware. When the detection logic offers an exception, the sequencer accepts it and records the faulting PC and the cause code so the handler can read them. It then pulses a flush that turns the younger in-flight instructions into bubbles and holds the fetch stage. After that it steps one injected micro-operation through three stages: EX forms the table-entry address, MEM reads that entry over a data-memory read port, and WB loads the PC with the handler address.

The table starts at a fixed base set by the parameter `TABLE_BASE`. Each entry is one machine word. A read that comes back with an error sends the PC to the parameter `FALLBACK_PC`, so a broken table cannot start the sequence again. Fetch stays held until the PC write, so the handler's first fetch comes after WB.

Back-pressure rules:
- **Exception input.** This is a valid/ready stream. An exception is taken on a cycle where `exc_valid_i` and `exc_ready_o` are both high. `exc_ready_o` depends only on internal state. The offering side must keep `exc_valid_i`, `exc_cause_i` and `exc_pc_i` steady until the exception is taken.
- **Read request.** The request stream holds its valid and address until the memory takes it.
- **Read response.** The response has no ready, because the block always accepts it while waiting. A response may arrive at the earliest one cycle after the request is taken. Responses that arrive at any other time are ignored.

Top module: `exc_vector_dispatch`

## Requirements
- R1: After reset, the block is idle:
  - `exc_ready_o` is 1.
  - `fetch_hold_o`, `flush_o`, `rd_req_valid_o` and `pc_load_o` are 0.
  - `uop_stage_o` is 0.
- R2: An exception is taken on a cycle where `exc_valid_i` and `exc_ready_o` are both high. In the next cycle:
  - `flush_o` is 1, for exactly that one cycle.
  - `saved_pc_o` and `saved_cause_o` show the taken PC and cause.
  - They keep those values until the next exception is taken.
- R3: In the cycle after the flush, `rd_req_valid_o` rises with `rd_addr_o` = `TABLE_BASE` + cause × 4, that is, the cause shifted left by two.
- R4: While `rd_req_valid_o` is high and `rd_req_ready_i` is low, the request stays valid and `rd_addr_o` does not change.
- R5: A response is accepted on the first cycle, after the request is taken, on which `rd_rsp_valid_i` is high. On the next cycle `pc_load_o` is 1 for exactly one cycle, with `pc_value_o` equal to the returned word.
- R6: If the accepted response has `rd_rsp_err_i` = 1, `pc_value_o` in the load cycle is `FALLBACK_PC`.
- R7: `fetch_hold_o` is high, and `exc_ready_o` is low, from the flush cycle through the PC-load cycle inclusive. An exception offered during that span is not taken, and the saved PC and cause keep their values.
- R8: `uop_stage_o` is one-hot or zero:
  - bit 0 (EX) in the flush cycle;
  - bit 1 (MEM) while the request or the response is pending;
  - bit 2 (WB) in the PC-load cycle;
  - zero when idle.
- R9: A response that arrives while no request is outstanding has no effect. It does not cause a PC load, and it does not change the value that is later loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | Exception offered by detection logic |
| exc_ready_o | output | 1 | Sequencer idle and able to take an exception |
| exc_cause_i | input | CAUSE_W | Cause code of offered exception |
| exc_pc_i | input | XLEN | PC of the faulting instruction |
| flush_o | output | 1 | One-cycle pulse: squash younger in-flight instructions |
| fetch_hold_o | output | 1 | Stall the fetch stage |
| uop_stage_o | output | 3 | Stage of the injected micro-op (bit0 EX, bit1 MEM, bit2 WB) |
| rd_req_valid_o | output | 1 | Table read request valid |
| rd_req_ready_i | input | 1 | Memory takes the read request |
| rd_addr_o | output | XLEN | Byte address of the table entry |
| rd_rsp_valid_i | input | 1 | Read data returned |
| rd_rsp_data_i | input | XLEN | Handler address read from the table |
| rd_rsp_err_i | input | 1 | Read hit an invalid address |
| pc_load_o | output | 1 | Load the PC this cycle |
| pc_value_o | output | XLEN | New PC value |
| saved_pc_o | output | XLEN | PC of the last taken exception |
| saved_cause_o | output | CAUSE_W | Cause of the last taken exception |

## Verification
Relative to the edge that takes an exception:
- The flush, the saved values and the EX stage appear in the first cycle after that edge.
- The read request appears in the second cycle.
- `pc_load_o` follows exactly one cycle after the edge that accepts the response, whatever number of wait cycles came before.

The bench keeps to this timing by moving one clock edge at a time and sampling 1 ns after each edge, once the registered outputs have settled. It checks each output in the specific cycle where it is due and also in the cycles on either side. Stalls in the request, late responses and stray responses shift the expected cycle by exactly the number of cycles the bench inserted.

// File: rtl/evd_pkg.sv
package evd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_EXEC = 3'd1,
    ST_MREQ = 3'd2,
    ST_MRSP = 3'd3,
    ST_WBK  = 3'd4
  } evd_state_e;

  localparam int STG_EX  = 0;
  localparam int STG_MEM = 1;
  localparam int STG_WB  = 2;
  localparam int STG_N   = 3;

  function automatic logic [STG_N-1:0] stage_of(input evd_state_e st);
    logic [STG_N-1:0] v;
    v = '0;
    case (st)
      ST_EXEC:          v[STG_EX]  = 1'b1;
      ST_MREQ, ST_MRSP: v[STG_MEM] = 1'b1;
      ST_WBK:           v[STG_WB]  = 1'b1;
      default:          v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/evd_fsm.sv
module evd_fsm
  import evd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_i,
  input  logic       req_hs_i,
  input  logic       rsp_valid_i,
  output evd_state_e state_o
);

  evd_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (take_i)      st_d = ST_EXEC;
      ST_EXEC:                  st_d = ST_MREQ;
      ST_MREQ: if (req_hs_i)    st_d = ST_MRSP;
      ST_MRSP: if (rsp_valid_i) st_d = ST_WBK;
      ST_WBK:                   st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

endmodule

// File: rtl/evd_capture.sv
module evd_capture #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    pc_o,
  output logic [CAUSE_W-1:0] cause_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o    <= '0;
      cause_o <= '0;
    end else if (take_i) begin
      pc_o    <= pc_i;
      cause_o <= cause_i;
    end
  end

endmodule

// File: rtl/evd_entry_addr.sv
module evd_entry_addr #(
  parameter int              XLEN       = 32,
  parameter int              CAUSE_W    = 5,
  parameter logic [XLEN-1:0] TABLE_BASE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    addr_o
);

  localparam int ENTRY_BYTES = XLEN / 8;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

  logic [XLEN-1:0] cause_ext;
  logic [XLEN-1:0] offset;

  assign cause_ext = {{(XLEN-CAUSE_W){1'b0}}, cause_i};

  generate
    if (ENTRY_SHIFT == 0) begin : g_noscale
      assign offset = cause_ext;
    end else begin : g_scale
      assign offset = cause_ext << ENTRY_SHIFT;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_o <= '0;
    else if (load_i) addr_o <= TABLE_BASE + offset;
  end

endmodule

// File: rtl/evd_target_sel.sv
module evd_target_sel #(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] FALLBACK_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  input  logic            err_i,
  input  logic [XLEN-1:0] data_i,
  output logic [XLEN-1:0] target_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)        target_o <= '0;
    else if (accept_i) target_o <= err_i ? FALLBACK_PC : data_i;
  end

endmodule

// File: rtl/exc_vector_dispatch.sv
module exc_vector_dispatch
  import evd_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              CAUSE_W     = 5,
  parameter logic [XLEN-1:0] TABLE_BASE  = 32'h0000_0800,
  parameter logic [XLEN-1:0] FALLBACK_PC = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid_i,
  output logic               exc_ready_o,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [XLEN-1:0]    exc_pc_i,
  output logic               flush_o,
  output logic               fetch_hold_o,
  output logic [2:0]         uop_stage_o,
  output logic               rd_req_valid_o,
  input  logic               rd_req_ready_i,
  output logic [XLEN-1:0]    rd_addr_o,
  input  logic               rd_rsp_valid_i,
  input  logic [XLEN-1:0]    rd_rsp_data_i,
  input  logic               rd_rsp_err_i,
  output logic               pc_load_o,
  output logic [XLEN-1:0]    pc_value_o,
  output logic [XLEN-1:0]    saved_pc_o,
  output logic [CAUSE_W-1:0] saved_cause_o
);

  evd_state_e st;
  logic       take;
  logic       req_hs;
  logic       rsp_accept;

  assign exc_ready_o = (st == ST_IDLE);
  assign take        = exc_valid_i && exc_ready_o;
  assign req_hs      = rd_req_valid_o && rd_req_ready_i;
  assign rsp_accept  = (st == ST_MRSP) && rd_rsp_valid_i;

  evd_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .req_hs_i    (req_hs),
    .rsp_valid_i (rd_rsp_valid_i),
    .state_o     (st)
  );

  evd_capture #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .pc_i    (exc_pc_i),
    .cause_i (exc_cause_i),
    .pc_o    (saved_pc_o),
    .cause_o (saved_cause_o)
  );

  evd_entry_addr #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .TABLE_BASE(TABLE_BASE)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (st == ST_EXEC),
    .cause_i (saved_cause_o),
    .addr_o  (rd_addr_o)
  );

  evd_target_sel #(.XLEN(XLEN), .FALLBACK_PC(FALLBACK_PC)) u_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (rsp_accept),
    .err_i    (rd_rsp_err_i),
    .data_i   (rd_rsp_data_i),
    .target_o (pc_value_o)
  );

  assign flush_o        = (st == ST_EXEC);
  assign fetch_hold_o   = (st != ST_IDLE);
  assign rd_req_valid_o = (st == ST_MREQ);
  assign pc_load_o      = (st == ST_WBK);
  assign uop_stage_o    = stage_of(st);

endmodule

// File: rtl/evd_dispatch_checker.sv
module evd_dispatch_checker #(
  parameter int              XLEN        = 32,
  parameter int              CAUSE_W     = 5,
  parameter logic [XLEN-1:0] TABLE_BASE  = '0,
  parameter logic [XLEN-1:0] FALLBACK_PC = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exc_valid_i,
  input logic               exc_ready_o,
  input logic               flush_o,
  input logic               fetch_hold_o,
  input logic [2:0]         uop_stage_o,
  input logic               rd_req_valid_o,
  input logic               rd_req_ready_i,
  input logic [XLEN-1:0]    rd_addr_o,
  input logic               rd_rsp_valid_i,
  input logic [XLEN-1:0]    rd_rsp_data_i,
  input logic               rd_rsp_err_i,
  input logic               pc_load_o,
  input logic [XLEN-1:0]    pc_value_o,
  input logic [CAUSE_W-1:0] saved_cause_o
);

  localparam logic [XLEN-1:0] WORD_BYTES = XLEN / 8;

  logic rsp_taken;
  assign rsp_taken = uop_stage_o[1] && !rd_req_valid_o && rd_rsp_valid_i;

  AST_IDLE_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) exc_ready_o |-> (!rd_req_valid_o && !pc_load_o && !flush_o)); // R1
  AST_TAKE_FLUSH:     assert property (@(posedge clk) disable iff (!rst_n) (exc_valid_i && exc_ready_o) |=> flush_o); // R2
  AST_FLUSH_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) flush_o |=> !flush_o); // R2
  AST_ENTRY_ADDR:     assert property (@(posedge clk) disable iff (!rst_n) rd_req_valid_o |-> (rd_addr_o == TABLE_BASE + XLEN'(saved_cause_o) * WORD_BYTES)); // R3
  AST_REQ_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o && $stable(rd_addr_o))); // R4
  AST_LOAD_VALUE:     assert property (@(posedge clk) disable iff (!rst_n) (rsp_taken && !rd_rsp_err_i) |=> (pc_load_o && pc_value_o == $past(rd_rsp_data_i))); // R5
  AST_LOAD_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) pc_load_o |=> !pc_load_o); // R5
  AST_ERR_FALLBACK:   assert property (@(posedge clk) disable iff (!rst_n) (rsp_taken && rd_rsp_err_i) |=> (pc_load_o && pc_value_o == FALLBACK_PC)); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) fetch_hold_o |-> !exc_ready_o); // R7
  AST_HOLD_AT_LOAD:   assert property (@(posedge clk) disable iff (!rst_n) pc_load_o |-> fetch_hold_o); // R7
  AST_STAGE_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(uop_stage_o)); // R8
  AST_STAGE_WB:       assert property (@(posedge clk) disable iff (!rst_n) pc_load_o |-> uop_stage_o[2]); // R8

endmodule

bind exc_vector_dispatch evd_dispatch_checker #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .TABLE_BASE(TABLE_BASE), .FALLBACK_PC(FALLBACK_PC)
) u_evd_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .exc_valid_i    (exc_valid_i),
  .exc_ready_o    (exc_ready_o),
  .flush_o        (flush_o),
  .fetch_hold_o   (fetch_hold_o),
  .uop_stage_o    (uop_stage_o),
  .rd_req_valid_o (rd_req_valid_o),
  .rd_req_ready_i (rd_req_ready_i),
  .rd_addr_o      (rd_addr_o),
  .rd_rsp_valid_i (rd_rsp_valid_i),
  .rd_rsp_data_i  (rd_rsp_data_i),
  .rd_rsp_err_i   (rd_rsp_err_i),
  .pc_load_o      (pc_load_o),
  .pc_value_o     (pc_value_o),
  .saved_cause_o  (saved_cause_o)
);

// File: tb/exc_vector_dispatch_test.sv
`timescale 1ns/1ps
module exc_vector_dispatch_test;

  localparam int          XLEN  = 32;
  localparam int          CW    = 5;
  localparam logic [31:0] BASE  = 32'h0000_1000;
  localparam logic [31:0] FALLB = 32'h0000_0F00;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          exc_valid = 1'b0;
  logic          exc_ready;
  logic [CW-1:0] exc_cause = '0;
  logic [31:0]   exc_pc = '0;
  logic          flush, fetch_hold;
  logic [2:0]    stage;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [31:0]   rd_addr;
  logic          rsp_valid = 1'b0;
  logic [31:0]   rsp_data = '0;
  logic          rsp_err = 1'b0;
  logic          pc_load;
  logic [31:0]   pc_value, saved_pc;
  logic [CW-1:0] saved_cause;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  exc_vector_dispatch #(
    .XLEN(XLEN), .CAUSE_W(CW), .TABLE_BASE(BASE), .FALLBACK_PC(FALLB)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .exc_valid_i(exc_valid), .exc_ready_o(exc_ready),
    .exc_cause_i(exc_cause), .exc_pc_i(exc_pc),
    .flush_o(flush), .fetch_hold_o(fetch_hold), .uop_stage_o(stage),
    .rd_req_valid_o(req_valid), .rd_req_ready_i(req_ready), .rd_addr_o(rd_addr),
    .rd_rsp_valid_i(rsp_valid), .rd_rsp_data_i(rsp_data), .rd_rsp_err_i(rsp_err),
    .pc_load_o(pc_load), .pc_value_o(pc_value),
    .saved_pc_o(saved_pc), .saved_cause_o(saved_cause)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] entry(input logic [CW-1:0] c);
    return BASE + 32'(c) * 32'd4;
  endfunction

  task automatic t_reset();
    chk("R1", "exc_ready", 32'(exc_ready), 1);
    chk("R1", "fetch_hold", 32'(fetch_hold), 0);
    chk("R1", "flush", 32'(flush), 0);
    chk("R1", "req_valid", 32'(req_valid), 0);
    chk("R1", "pc_load", 32'(pc_load), 0);
    chk("R1", "stage", 32'(stage), 0);
  endtask

  task automatic t_basic();
    exc_valid = 1; exc_cause = 5'd3; exc_pc = 32'h0000_0100;
    tick();
    exc_valid = 0;
    chk("R2", "flush", 32'(flush), 1);
    chk("R2", "saved_pc", saved_pc, 32'h100);
    chk("R2", "saved_cause", 32'(saved_cause), 3);
    chk("R8", "stage EX", 32'(stage), 3'b001);
    chk("R7", "hold at flush", 32'(fetch_hold), 1);
    chk("R7", "ready low", 32'(exc_ready), 0);
    chk("R3", "no req yet", 32'(req_valid), 0);
    req_ready = 1;
    tick();
    chk("R2", "flush one cycle", 32'(flush), 0);
    chk("R3", "req_valid", 32'(req_valid), 1);
    chk("R3", "rd_addr", rd_addr, 32'h0000_100C);
    chk("R8", "stage MEM", 32'(stage), 3'b010);
    tick();
    req_ready = 0;
    chk("R5", "req dropped after handshake", 32'(req_valid), 0);
    chk("R5", "no load while waiting", 32'(pc_load), 0);
    rsp_valid = 1; rsp_data = 32'h0000_4000;
    tick();
    rsp_valid = 0; rsp_data = '0;
    chk("R5", "pc_load", 32'(pc_load), 1);
    chk("R5", "pc_value", pc_value, 32'h0000_4000);
    chk("R8", "stage WB", 32'(stage), 3'b100);
    chk("R7", "hold at load", 32'(fetch_hold), 1);
    tick();
    chk("R5", "load one cycle", 32'(pc_load), 0);
    chk("R7", "hold released", 32'(fetch_hold), 0);
    chk("R7", "ready again", 32'(exc_ready), 1);
    chk("R2", "saved_pc kept", saved_pc, 32'h100);
  endtask

  task automatic t_backpressure();
    exc_valid = 1; exc_cause = 5'd31; exc_pc = 32'h0000_0A04;
    tick();
    exc_valid = 0;
    tick();
    for (int i = 0; i < 3; i++) begin
      chk("R4", "req held", 32'(req_valid), 1);
      chk("R4", "addr stable", rd_addr, entry(5'd31));
      tick();
    end
    chk("R3", "max cause addr", rd_addr, 32'h0000_107C);
    req_ready = 1;
    tick();
    req_ready = 0;
    tick();
    tick();
    chk("R5", "no load before rsp", 32'(pc_load), 0);
    chk("R8", "stage MEM waiting", 32'(stage), 3'b010);
    rsp_valid = 1; rsp_data = 32'h0000_5550;
    tick();
    rsp_valid = 0;
    chk("R5", "late rsp load", 32'(pc_load), 1);
    chk("R5", "late rsp value", pc_value, 32'h0000_5550);
    tick();
  endtask

  task automatic t_error();
    exc_valid = 1; exc_cause = 5'd0; exc_pc = 32'h0000_0C00;
    tick();
    exc_valid = 0; req_ready = 1;
    tick();
    chk("R3", "cause 0 addr", rd_addr, BASE);
    tick();
    req_ready = 0;
    rsp_valid = 1; rsp_err = 1; rsp_data = 32'hDEAD_BEEF;
    tick();
    rsp_valid = 0; rsp_err = 0;
    chk("R6", "pc_load", 32'(pc_load), 1);
    chk("R6", "fallback value", pc_value, FALLB);
    tick();
  endtask

  task automatic t_busy_hold();
    exc_valid = 1; exc_cause = 5'd5; exc_pc = 32'h0000_0200;
    tick();
    exc_cause = 5'd9; exc_pc = 32'h0000_0300;
    req_ready = 1;
    chk("R7", "ready low in EX", 32'(exc_ready), 0);
    tick();
    chk("R7", "saved cause kept", 32'(saved_cause), 5);
    chk("R7", "saved pc kept", saved_pc, 32'h200);
    chk("R7", "ready low in MEM", 32'(exc_ready), 0);
    chk("R3", "addr first cause", rd_addr, entry(5'd5));
    tick();
    req_ready = 0;
    rsp_valid = 1; rsp_data = 32'h0000_6000;
    tick();
    rsp_valid = 0;
    chk("R7", "ready low at load", 32'(exc_ready), 0);
    chk("R7", "saved cause kept at load", 32'(saved_cause), 5);
    tick();
    chk("R7", "ready after load", 32'(exc_ready), 1);
    tick();
    exc_valid = 0;
    chk("R2", "pending taken cause", 32'(saved_cause), 9);
    chk("R2", "pending taken pc", saved_pc, 32'h300);
    chk("R2", "pending flush", 32'(flush), 1);
    req_ready = 1;
    tick();
    tick();
    req_ready = 0;
    rsp_valid = 1; rsp_data = 32'h0000_6100;
    tick();
    rsp_valid = 0;
    chk("R5", "second load value", pc_value, 32'h0000_6100);
    tick();
  endtask

  task automatic t_stray();
    rsp_valid = 1; rsp_data = 32'h1111_2222;
    tick();
    rsp_valid = 0;
    chk("R9", "idle stray no load", 32'(pc_load), 0);
    chk("R9", "idle stray ready", 32'(exc_ready), 1);
    tick();
    chk("R9", "idle stray no load later", 32'(pc_load), 0);
    exc_valid = 1; exc_cause = 5'd7; exc_pc = 32'h0000_0400;
    tick();
    exc_valid = 0;
    rsp_valid = 1; rsp_data = 32'h3333_4444;
    tick();
    rsp_valid = 0;
    chk("R9", "stray in EX no load", 32'(pc_load), 0);
    chk("R9", "stray: req still issued", 32'(req_valid), 1);
    rsp_valid = 1; rsp_data = 32'h5555_6666;
    tick();
    rsp_valid = 0;
    chk("R9", "stray during req no load", 32'(pc_load), 0);
    req_ready = 1;
    tick();
    req_ready = 0;
    rsp_valid = 1; rsp_data = 32'h0000_7000;
    tick();
    rsp_valid = 0;
    chk("R9", "real value after strays", pc_value, 32'h0000_7000);
    chk("R9", "load after strays", 32'(pc_load), 1);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_basic();
    t_backpressure();
    t_error();
    t_busy_hold();
    t_stray();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule